// File: doc/BRIEF.md
# Fractional UART Baud Tick Generator

This block derives the 16x oversampling strobe for a UART transmitter or receiver from a single reference clock. Each data bit is split into sixteen sample periods. A sample period normally lasts `div_in + 1` reference clocks. Selected sample periods last one clock more, so a fractional clocks-per-bit ratio is spread across the bit rather than being rounded away. The stretched periods are chosen either by a 16-bit slot pattern or, in a build-time variant, by a plain 4-bit remainder count.

The divider and fraction inputs are held in shadow registers. While the generator is idle the shadows follow the inputs. While it runs they are reloaded only on the clock that closes a bit. A shift engine consumes the `tick` strobe, uses `sample_idx` to pick its mid-bit sample, and advances its bit counter on `bit_end`.

The control is a three-state machine:
- `ST_IDLE`: enable low. Counters are held at zero.
- `ST_COUNT`: counting the `div+1` base clocks of a sample period.
- `ST_EXTRA`: the one added clock of a stretched period.

The transitions are:
- start: `ST_IDLE` to `ST_COUNT` when enable rises.
- stretch: `ST_COUNT` to `ST_EXTRA` when the base count ends on a flagged slot.
- advance: `ST_COUNT` to `ST_COUNT`, or `ST_EXTRA` to `ST_COUNT`, at the end of a period.
- stop: any state to `ST_IDLE` when enable is low.

Top module: `baud_tick_gen`

## Requirements
- R1: After synchronous reset (`rst` high), `tick`, `bit_end` and `sample_idx` are all zero.
- R2: When its slot is not flagged, a sample period lasts exactly `div_in+1` clocks. `tick` is high for one clock at the end of each period, and never for two clocks in a row when the divider is non-zero.
- R3: In pattern mode (`PATTERN_MODE=1`), bit i of the slot value (bit 0 = LSB) flags sample period i, counting from sample 0 at the start of the bit. A flagged period lasts `div_in+2` clocks.
- R4: The number of clocks from one `bit_end` pulse to the next equals `(div_in+1)*16` plus the number of set bits in the slot value.
- R5: `sample_idx` names the sample period in progress. It counts 0 to 15 and advances by one, with wrap-around, on the clock after each `tick`. `bit_end` pulses together with the `tick` that ends sample 15, so each bit contains exactly 16 ticks.
- R6: A change to `div_in` or `slot_in` while running does not alter the bit in progress. It applies from the next bit.
- R7: While `enable` is low, no `tick` or `bit_end` occurs, and `sample_idx` is zero from the clock after `enable` fell. After `enable` rises, the first `tick` comes `div_in+1` clocks later.
- R8: In remainder mode (`PATTERN_MODE=0`), `slot_in` is a 4-bit count r. Sample periods 0 to r-1 are stretched, so each bit gets exactly r extra clocks.
- R9: For every remainder k from 0 to 15, the spread pattern with exactly k set bits yields a bit of `(div_in+1)*16+k` clocks. The patterns are 0000, 0080, 0808, 0888, 2222, 4924, 4A52, 54AA, 5555, D555, D5D5, DDD5, DDDD, DFDD, DFDF and FFDF, in hex.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run control; low holds counters at zero |
| div_in | input | DIV_W | Integer divider: base sample period is value+1 clocks |
| slot_in | input | FRAC_W | Stretch pattern (16 bits) or remainder count (4 bits) |
| tick | output | 1 | One-clock strobe at the end of each sample period |
| sample_idx | output | 4 | Index of the current sample period within the bit |
| bit_end | output | 1 | Strobe on the tick that closes sample 15 |

## Verification
A corrupted period counter or a wrong state shows as a misplaced `tick` within one sample period, at most `div_in+2` clocks. A skipped or repeated sample index shows as a wrong `sample_idx` at the next tick, and as a bit that does not hold 16 ticks at the next `bit_end`. A shadow register loaded at the wrong time shows only at bit granularity, as one bit of the wrong length. The bench therefore measures the length of every sample period and every bit, and the change test compares the bit in progress with the one after it.

// File: rtl/baud_pkg.sv
package baud_pkg;
    localparam int SLOT_N = 16;
    localparam int IDX_W  = $clog2(SLOT_N);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_EXTRA = 2'd2
    } baud_state_t;
endpackage

// File: rtl/baud_shadow.sv
module baud_shadow #(
    parameter int DIV_W  = 12,
    parameter int FRAC_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DIV_W-1:0]  div_in,
    input  logic [FRAC_W-1:0] frac_in,
    output logic [DIV_W-1:0]  div_q,
    output logic [FRAC_W-1:0] frac_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            frac_q <= '0;
        end else if (load) begin
            div_q  <= div_in;
            frac_q <= frac_in;
        end
    end
endmodule

// File: rtl/baud_stretch.sv
module baud_stretch
    import baud_pkg::*;
#(
    parameter bit PATTERN_MODE = 1'b1,
    parameter int FRAC_W       = 16
) (
    input  logic [FRAC_W-1:0] frac_q,
    input  logic [IDX_W-1:0]  idx,
    output logic              stretch
);
    generate
        if (PATTERN_MODE) begin : g_pattern
            // one flag per sample slot, slot 0 first
            assign stretch = frac_q[idx];
        end else begin : g_remainder
            // remainder r stretches slots 0 .. r-1
            assign stretch = (idx < frac_q);
        end
    endgenerate
endmodule

// File: rtl/baud_fsm.sv
module baud_fsm
    import baud_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [DIV_W-1:0] div_q,
    input  logic             stretch,
    output logic             tick,
    output logic [IDX_W-1:0] idx,
    output logic             bit_end,
    output logic             running
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOT_N - 1);

    baud_state_t      state_q, state_d;
    logic [DIV_W-1:0] cnt_q, cnt_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             base_done;

    assign base_done = (cnt_q == div_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                idx_d = '0;
                if (enable) state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (!enable) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                    idx_d   = '0;
                end else if (base_done) begin
                    cnt_d = '0;
                    if (stretch) begin
                        state_d = ST_EXTRA;
                    end else begin
                        idx_d = idx_q + IDX_W'(1);
                    end
                end else begin
                    cnt_d = cnt_q + DIV_W'(1);
                end
            end
            ST_EXTRA: begin
                cnt_d = '0;
                if (!enable) begin
                    state_d = ST_IDLE;
                    idx_d   = '0;
                end else begin
                    state_d = ST_COUNT;
                    idx_d   = idx_q + IDX_W'(1);
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
                idx_d   = '0;
            end
        endcase
    end

    always_comb begin
        tick    = 1'b0;
        running = (state_q != ST_IDLE);
        unique case (state_q)
            ST_IDLE:  tick = 1'b0;
            ST_COUNT: tick = enable && base_done && !stretch;
            ST_EXTRA: tick = enable;
            default:  tick = 1'b0;
        endcase
        idx     = idx_q;
        bit_end = tick && (idx_q == LAST_IDX);
    end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_pkg::*;
#(
    parameter int  DIV_W        = 12,
    parameter bit  PATTERN_MODE = 1'b1,
    localparam int FRAC_W       = PATTERN_MODE ? SLOT_N : IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [DIV_W-1:0]  div_in,
    input  logic [FRAC_W-1:0] slot_in,
    output logic              tick,
    output logic [IDX_W-1:0]  sample_idx,
    output logic              bit_end
);
    logic [DIV_W-1:0]  div_q;
    logic [FRAC_W-1:0] frac_q;
    logic              stretch;
    logic              running;
    logic              shadow_load;

    // shadows follow inputs while idle, otherwise reload only at a bit boundary
    assign shadow_load = !running || bit_end;

    baud_shadow #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_shadow (
        .clk     (clk),
        .rst     (rst),
        .load    (shadow_load),
        .div_in  (div_in),
        .frac_in (slot_in),
        .div_q   (div_q),
        .frac_q  (frac_q)
    );

    baud_stretch #(.PATTERN_MODE(PATTERN_MODE), .FRAC_W(FRAC_W)) u_stretch (
        .frac_q  (frac_q),
        .idx     (sample_idx),
        .stretch (stretch)
    );

    baud_fsm #(.DIV_W(DIV_W)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .enable  (enable),
        .div_q   (div_q),
        .stretch (stretch),
        .tick    (tick),
        .idx     (sample_idx),
        .bit_end (bit_end),
        .running (running)
    );
endmodule

// File: rtl/baud_tick_chk.sv
module baud_tick_chk #(
    parameter int DIV_W  = 12,
    parameter int FRAC_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              enable,
    input logic              tick,
    input logic [3:0]        sample_idx,
    input logic              bit_end,
    input logic              running,
    input logic [DIV_W-1:0]  div_q,
    input logic [FRAC_W-1:0] frac_q
);
    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && div_q != '0) |=> !tick);

    assert_idx_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (enable && !tick) |=> $stable(sample_idx));

    assert_idx_step_R5: assert property (@(posedge clk) disable iff (rst)
        tick |=> (sample_idx == $past(sample_idx) + 4'd1));

    assert_bit_follows_last_R5: assert property (@(posedge clk) disable iff (rst)
        bit_end |=> (sample_idx == 4'd0));

    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (sample_idx == 4'd0));

    assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (running && !bit_end) |=> ($stable(div_q) && $stable(frac_q)));

    always @(posedge clk) begin
        if (!rst) begin
            assert_no_idle_tick_R7: assert (enable || !tick);
        end
    end
endmodule

bind baud_tick_gen baud_tick_chk #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .tick       (tick),
    .sample_idx (sample_idx),
    .bit_end    (bit_end),
    .running    (running),
    .div_q      (div_q),
    .frac_q     (frac_q)
);

// File: tb/sim_baud_tick_gen.sv
`timescale 1ns/1ps
module sim_baud_tick_gen;
    localparam int DIV_W = 12;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             en  = 1'b0;
    logic [DIV_W-1:0] div = '0;
    logic [15:0]      pat = '0;
    logic [3:0]       rem = '0;

    logic       tick0, bit0, tick1, bit1;
    logic [3:0] idx0, idx1;

    always #4 clk = ~clk;   // 125 MHz

    baud_tick_gen #(.DIV_W(DIV_W), .PATTERN_MODE(1'b1)) u0 (
        .clk(clk), .rst(rst), .enable(en), .div_in(div), .slot_in(pat),
        .tick(tick0), .sample_idx(idx0), .bit_end(bit0));

    baud_tick_gen #(.DIV_W(DIV_W), .PATTERN_MODE(1'b0)) u1 (
        .clk(clk), .rst(rst), .enable(en), .div_in(div), .slot_in(rem),
        .tick(tick1), .sample_idx(idx1), .bit_end(bit1));

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    // measurement state, sampled on the falling edge
    int per0 [16];
    int per1 [16];
    int tg0, tg1, bg0, bg1, tc0, tc1;
    int bitper0, bitper1, tpb0, tpb1, nbits0, nbits1;
    int idx_err, bit_err, exp0, exp1;

    function automatic logic [15:0] spread(input int k);
        case (k)
            0:  spread = 16'h0000;  1:  spread = 16'h0080;
            2:  spread = 16'h0808;  3:  spread = 16'h0888;
            4:  spread = 16'h2222;  5:  spread = 16'h4924;
            6:  spread = 16'h4A52;  7:  spread = 16'h54AA;
            8:  spread = 16'h5555;  9:  spread = 16'hD555;
            10: spread = 16'hD5D5;  11: spread = 16'hDDD5;
            12: spread = 16'hDDDD;  13: spread = 16'hDFDD;
            14: spread = 16'hDFDF;  default: spread = 16'hFFDF;
        endcase
    endfunction

    always @(negedge clk) begin
        cycles++;
        if (rst || !en) begin
            tg0 = 0; tg1 = 0; bg0 = 0; bg1 = 0; tc0 = 0; tc1 = 0;
            exp0 = 0; exp1 = 0;
        end else begin
            if (tick0) begin
                per0[idx0] = tg0 + 1; tg0 = 0; tc0++;
                if (int'(idx0) != exp0) idx_err++;
                exp0 = (int'(idx0) + 1) % 16;
            end else tg0++;
            if (tick1) begin
                per1[idx1] = tg1 + 1; tg1 = 0; tc1++;
                if (int'(idx1) != exp1) idx_err++;
                exp1 = (int'(idx1) + 1) % 16;
            end else tg1++;
            if (bit0) begin
                if (!tick0 || idx0 != 4'd15) bit_err++;
                bitper0 = bg0 + 1; bg0 = 0; tpb0 = tc0; tc0 = 0; nbits0++;
            end else bg0++;
            if (bit1) begin
                if (!tick1 || idx1 != 4'd15) bit_err++;
                bitper1 = bg1 + 1; bg1 = 0; tpb1 = tc1; tc1 = 0; nbits1++;
            end else bg1++;
        end
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_bits(input int n);
        int t0;
        t0 = nbits0;
        while (nbits0 < t0 + n) @(negedge clk);
    endtask

    task automatic start_cfg(input int d, input logic [15:0] p, input logic [3:0] r);
        @(negedge clk);
        en = 1'b0;
        repeat (2) @(negedge clk);
        div = DIV_W'(d); pat = p; rem = r;
        en = 1'b1;
        wait_bits(3);
    endtask

    task automatic t_reset_R1();
        rst = 1'b1; en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(tick0 == 1'b0 && bit0 == 1'b0, "R1 strobes after reset", int'(tick0) + int'(bit0), 0);
        chk(idx0 == 4'd0 && idx1 == 4'd0, "R1 sample_idx after reset", int'(idx0), 0);
    endtask

    task automatic t_first_tick_R7();
        int late;
        @(negedge clk);
        en = 1'b0; div = DIV_W'(3); pat = '0; rem = '0;
        repeat (2) @(negedge clk);
        en = 1'b1;
        late = 0;
        repeat (3) begin
            @(negedge clk);
            if (tick0) late++;
        end
        chk(late == 0, "R7 no early tick after enable", late, 0);
        @(negedge clk);
        chk(tick0 == 1'b1 && idx0 == 4'd0, "R7 first tick after div+1 clocks", int'(tick0), 1);
    endtask

    task automatic t_plain_period_R2();
        start_cfg(3, 16'h0000, 4'd0);
        chk(per0[0] == 4 && per0[7] == 4 && per0[15] == 4, "R2 plain period div+1", per0[7], 4);
        start_cfg(0, 16'h0000, 4'd0);
        chk(bitper0 == 16, "R2 div=0 gives one clock per sample", bitper0, 16);
    endtask

    task automatic t_order_R3_R8();
        start_cfg(3, 16'h0001, 4'd1);
        chk(per0[0] == 5 && per0[1] == 4, "R3 slot bit 0 stretches sample 0", per0[0], 5);
        chk(per1[0] == 5 && per1[1] == 4, "R8 remainder 1 stretches sample 0", per1[0], 5);
        start_cfg(3, 16'h8000, 4'd1);
        chk(per0[15] == 5 && per0[0] == 4, "R3 slot bit 15 stretches sample 15", per0[15], 5);
        chk(per1[15] == 4, "R8 remainder leaves sample 15 plain", per1[15], 4);
        start_cfg(2, 16'h0000, 4'd3);
        chk(per1[2] == 4 && per1[3] == 3, "R8 remainder 3 packs low slots", per1[3], 3);
    endtask

    task automatic t_sweep_R4_R9();
        int bad = 0;
        int bad1 = 0;
        int lastact = 0;
        int lastexp = 0;
        foreach (div_set[i]) begin
            for (int k = 0; k < 16; k++) begin
                int expect_clk;
                start_cfg(div_set[i], spread(k), 4'(k));
                expect_clk = (div_set[i] + 1) * 16 + $countones(spread(k));
                if (bitper0 != expect_clk) begin bad++; lastact = bitper0; lastexp = expect_clk; end
                if (bitper1 != (div_set[i] + 1) * 16 + k) bad1++;
                if (tpb0 != 16 || tpb1 != 16) bad++;
            end
        end
        chk(bad == 0, "R9 spread patterns clocks per bit", lastact, lastexp);
        chk(bad1 == 0, "R8 remainder mode clocks per bit", bad1, 0);
        start_cfg(5, 16'hA5C3, 4'd0);
        chk(bitper0 == 6 * 16 + 8, "R4 arbitrary pattern clocks per bit", bitper0, 104);
        start_cfg(1, 16'hFFFF, 4'd0);
        chk(bitper0 == 48, "R4 all slots stretched", bitper0, 48);
    endtask

    task automatic t_index_R5();
        chk(idx_err == 0, "R5 sample_idx sequence", idx_err, 0);
        chk(bit_err == 0, "R5 bit_end only with tick on sample 15", bit_err, 0);
        chk(tpb0 == 16, "R5 sixteen ticks per bit", tpb0, 16);
    endtask

    task automatic t_boundary_R6();
        start_cfg(2, 16'h0000, 4'd0);
        wait_bits(1);
        repeat (10) @(negedge clk);
        div = DIV_W'(5);
        wait_bits(1);
        chk(bitper0 == 48, "R6 bit in progress keeps old divider", bitper0, 48);
        wait_bits(1);
        chk(bitper0 == 96, "R6 next bit uses new divider", bitper0, 96);
        repeat (7) @(negedge clk);
        pat = 16'hFFFF; rem = 4'd9;
        wait_bits(1);
        chk(bitper0 == 96 && bitper1 == 96, "R6 bit in progress keeps old slots", bitper0, 96);
        wait_bits(1);
        chk(bitper0 == 112, "R6 next bit uses new slots", bitper0, 112);
        chk(bitper1 == 105, "R6 remainder change at boundary", bitper1, 105);
    endtask

    task automatic t_disable_R7();
        int seen = 0;
        start_cfg(1, 16'h0000, 4'd0);
        repeat (5) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk(idx0 == 4'd0 && idx1 == 4'd0, "R7 index cleared after disable", int'(idx0), 0);
        repeat (20) begin
            @(negedge clk);
            if (tick0 || tick1 || bit0 || bit1) seen++;
        end
        chk(seen == 0, "R7 no strobes while disabled", seen, 0);
    endtask

    int div_set [4] = '{0, 1, 3, 7};

    initial begin
        idx_err = 0; bit_err = 0; nbits0 = 0; nbits1 = 0;
        t_reset_R1();
        t_first_tick_R7();
        t_plain_period_R2();
        t_order_R3_R8();
        t_sweep_R4_R9();
        t_index_R5();
        t_boundary_R6();
        t_disable_R7();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule